// File: doc/BRIEF.md
# Shared Memory Reader-Writer Arbiter

This block decides which of N processors may use a single shared main memory at any moment. Each processor raises a read-request line, a write-request line, or both, and receives a read grant and a write grant in return. The block keeps one memory state that is idle, reading or writing. Any number of readers can hold the memory together. A writer holds it alone.

Readers always take precedence when the memory is idle. After a write completes, the memory passes through idle for one cycle. It then admits every processor that is waiting to read, as one batch, before the next writer is considered. Waiting writers are served round-robin. A grant stays up for as long as its request is held. The memory returns to idle one cycle after the last holder lets go. Data transfer, caching and memory timing are handled elsewhere. The block only hands out the rights to use the memory.

Top module: `mem_rw_arbiter`

## Requirements
- R1: After reset the state output reads idle and no grant is asserted. The state encoding is 2'b00 for idle, 2'b01 for reading and 2'b10 for writing. The value 2'b11 never appears.
- R2: At most one write grant is asserted at a time. No read grant is asserted while it is. The state reads writing exactly while a write grant is asserted.
- R3: Several read grants may be asserted together. The state reads reading exactly while at least one read grant is asserted.
- R4: A write grant is given only on the clock edge after a cycle in which the state was idle. A write request made while reading or writing waits without a grant.
- R5: When the state is idle and any read request is present, every requesting reader is granted on the next edge and the state becomes reading. This happens even if write requests are also pending.
- R6: While the state is reading, a newly raised read request is granted on the next edge.
- R7: A grant remains asserted for every cycle that its request stays asserted.
- R8: When the last reader drops its request, or the writer drops its request, the grant is removed on the next edge and the state returns to idle on that same edge.
- R9: When a write finishes while both reads and writes are pending, all pending reads are granted, one idle cycle later, before any writer.
- R10: Among pending writers, the next write grant goes to the first requesting processor after the previous write winner, in ascending index order with wrap-around. After reset the search starts at processor 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | N | Per-processor read request |
| wr_req | input | N | Per-processor write request |
| rd_gnt | output | N | Per-processor read grant, registered |
| wr_gnt | output | N | Per-processor write grant, registered (one-hot or zero) |
| mem_state | output | 2 | Memory state: 00 idle, 01 reading, 10 writing |

## Verification
Every output is a register, so a change of requests becomes visible after exactly one rising edge. The bench applies requests on a falling edge and checks on the next falling edge. Grants that pass through idle appear two edges after the request change. These are a write following the end of reading, reads following the end of a write, and the next writer in the rotation. The bench steps through that intermediate idle cycle and checks it before it looks for the grant. Hold behaviour is checked by sampling repeatedly across several cycles with unchanged requests.

// File: rtl/mem_rw_arb_pkg.sv
package mem_rw_arb_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'b00,
    MS_READ  = 2'b01,
    MS_WRITE = 2'b10
  } mem_state_e;
endpackage

// File: rtl/mem_rw_rr_pick.sv
// Round-robin search: first requester after index `last`, wrapping.
module mem_rw_rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    // descending offset so the nearest requester wins (assigned last)
    for (int k = N; k >= 1; k--) begin
      automatic int p = (int'(last) + k) % N;
      if (req[p]) begin
        found = 1'b1;
        idx   = IW'(p);
      end
    end
  end
endmodule

// File: rtl/mem_rw_ctrl.sv
// Next-state and next-grant logic for the reader-writer arbiter.
module mem_rw_ctrl
  import mem_rw_arb_pkg::*;
#(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  mem_state_e    st_q,
  input  logic [N-1:0]  rd_req,
  input  logic [N-1:0]  wr_req,
  input  logic [N-1:0]  rd_gnt_q,
  input  logic [N-1:0]  wr_gnt_q,
  input  logic          pick_found,
  input  logic [IW-1:0] pick_idx,
  output mem_state_e    st_d,
  output logic [N-1:0]  rd_gnt_d,
  output logic [N-1:0]  wr_gnt_d,
  output logic          take_wr
);
  always_comb begin
    st_d     = st_q;
    rd_gnt_d = rd_gnt_q;
    wr_gnt_d = wr_gnt_q;
    take_wr  = 1'b0;
    unique case (st_q)
      MS_IDLE: begin
        if (|rd_req) begin
          // readers first: whole batch admitted together
          st_d     = MS_READ;
          rd_gnt_d = rd_req;
        end else if (pick_found) begin
          st_d     = MS_WRITE;
          wr_gnt_d = N'(1) << pick_idx;
          take_wr  = 1'b1;
        end
      end
      MS_READ: begin
        if (|rd_req) begin
          rd_gnt_d = rd_req;   // late readers join, leavers drop
        end else begin
          rd_gnt_d = '0;
          st_d     = MS_IDLE;
        end
      end
      MS_WRITE: begin
        if (!(|(wr_gnt_q & wr_req))) begin
          wr_gnt_d = '0;
          st_d     = MS_IDLE;
        end
      end
      default: begin
        st_d     = MS_IDLE;
        rd_gnt_d = '0;
        wr_gnt_d = '0;
      end
    endcase
  end
endmodule

// File: rtl/mem_rw_arbiter.sv
module mem_rw_arbiter
  import mem_rw_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rd_req,
  input  logic [N-1:0] wr_req,
  output logic [N-1:0] rd_gnt,
  output logic [N-1:0] wr_gnt,
  output logic [1:0]   mem_state
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  mem_state_e    st_q, st_d;
  logic [N-1:0]  rd_gnt_q, rd_gnt_d, wr_gnt_q, wr_gnt_d;
  logic [IW-1:0] last_q, pick_idx;
  logic          pick_found, take_wr;

  mem_rw_rr_pick #(.N(N)) u_pick (
    .req   (wr_req),
    .last  (last_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  mem_rw_ctrl #(.N(N)) u_ctrl (
    .st_q       (st_q),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .rd_gnt_q   (rd_gnt_q),
    .wr_gnt_q   (wr_gnt_q),
    .pick_found (pick_found),
    .pick_idx   (pick_idx),
    .st_d       (st_d),
    .rd_gnt_d   (rd_gnt_d),
    .wr_gnt_d   (wr_gnt_d),
    .take_wr    (take_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= MS_IDLE;
      rd_gnt_q <= '0;
      wr_gnt_q <= '0;
      last_q   <= IW'(N - 1);
    end else begin
      st_q     <= st_d;
      rd_gnt_q <= rd_gnt_d;
      wr_gnt_q <= wr_gnt_d;
      if (take_wr) last_q <= pick_idx;
    end
  end

  assign rd_gnt    = rd_gnt_q;
  assign wr_gnt    = wr_gnt_q;
  assign mem_state = st_q;

  // R1: encoding stays legal
  a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
    st_q != 2'b11);
  // R2: lone writer, never alongside readers
  a_r2_single_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_gnt_q) && !((|wr_gnt_q) && (|rd_gnt_q)));
  a_r2_write_state: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_WRITE) == (|wr_gnt_q));
  // R3: reading state tracks read grants
  a_r3_read_state: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_READ) == (|rd_gnt_q));
  // R4: write only starts from idle
  a_r4_write_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(|wr_gnt_q) |-> ($past(st_q) == MS_IDLE));
  // R5: idle with readers waiting admits the whole batch
  a_r5_read_batch: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_IDLE && (|rd_req)) |=> (st_q == MS_READ && rd_gnt_q == $past(rd_req)));
  // R6: late readers join while reading
  a_r6_join_read: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_READ && (|rd_req)) |=> (rd_gnt_q == $past(rd_req)));
  // R7: writer keeps its grant while requesting
  a_r7_write_hold: assert property (@(posedge clk) disable iff (rst)
    (|(wr_gnt_q & wr_req)) |=> (wr_gnt_q == $past(wr_gnt_q)));
  // R8: release returns memory to idle on the next edge
  a_r8_write_release: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_WRITE && !(|(wr_gnt_q & wr_req))) |=> (st_q == MS_IDLE && wr_gnt_q == '0));
  a_r8_read_release: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_READ && !(|rd_req)) |=> (st_q == MS_IDLE && rd_gnt_q == '0));
endmodule

// File: tb/mem_rw_arbiter_bench.sv
module mem_rw_arbiter_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] rd_req = '0;
  logic [N-1:0] wr_req = '0;
  logic [N-1:0] rd_gnt, wr_gnt;
  logic [1:0]   mem_state;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mem_rw_arbiter #(.N(N)) u_mem_rw_arbiter (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .rd_gnt(rd_gnt), .wr_gnt(wr_gnt), .mem_state(mem_state)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic expect_all(input string req, input logic [1:0] st,
                            input logic [N-1:0] rg, input logic [N-1:0] wg);
    chk(req, "state", 32'(mem_state), 32'(st));
    chk(req, "rd_gnt", 32'(rd_gnt), 32'(rg));
    chk(req, "wr_gnt", 32'(wr_gnt), 32'(wg));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic reset_dut();
    rst = 1'b1; rd_req = '0; wr_req = '0;
    step(); step();
    rst = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    reset_dut();
    expect_all("R1", 2'b00, 4'b0000, 4'b0000);
  endtask

  // R3 R5 R6 R4 R8: reader batch, late reader, blocked writer
  task automatic t_readers();
    reset_dut();
    rd_req = 4'b0101; step();
    expect_all("R5", 2'b01, 4'b0101, 4'b0000);
    rd_req = 4'b0111; step();
    expect_all("R6", 2'b01, 4'b0111, 4'b0000);
    wr_req = 4'b1000;
    for (int i = 0; i < 3; i++) begin
      step();
      expect_all("R4", 2'b01, 4'b0111, 4'b0000);
    end
    rd_req = 4'b0000; step();
    expect_all("R8", 2'b00, 4'b0000, 4'b0000);
    step();
    expect_all("R4", 2'b10, 4'b0000, 4'b1000);
  endtask

  // R2 R7 R8 R9: writer holds, then readers beat other writers
  task automatic t_write_then_reads();
    reset_dut();
    wr_req = 4'b0001; step();
    expect_all("R2", 2'b10, 4'b0000, 4'b0001);
    rd_req = 4'b0110; wr_req = 4'b0101;
    for (int i = 0; i < 3; i++) begin
      step();
      expect_all("R7", 2'b10, 4'b0000, 4'b0001);
    end
    wr_req = 4'b0100; step();
    expect_all("R8", 2'b00, 4'b0000, 4'b0000);
    step();
    expect_all("R9", 2'b01, 4'b0110, 4'b0000);
    rd_req = 4'b0000; step();
    expect_all("R8", 2'b00, 4'b0000, 4'b0000);
    step();
    expect_all("R10", 2'b10, 4'b0000, 4'b0100);
  endtask

  // R10: rotation among writers with wrap-around
  task automatic t_round_robin();
    reset_dut();
    wr_req = 4'b1111; step();
    expect_all("R10", 2'b10, 4'b0000, 4'b0001);
    wr_req = 4'b1110; step();
    expect_all("R8", 2'b00, 4'b0000, 4'b0000);
    step();
    expect_all("R10", 2'b10, 4'b0000, 4'b0010);
    wr_req = 4'b1101; step(); step();
    expect_all("R10", 2'b10, 4'b0000, 4'b0100);
    wr_req = 4'b1011; step(); step();
    expect_all("R10", 2'b10, 4'b0000, 4'b1000);
    wr_req = 4'b0011; step(); step();
    expect_all("R10", 2'b10, 4'b0000, 4'b0001);
  endtask

  initial begin
    t_reset();
    t_readers();
    t_write_then_reads();
    t_round_robin();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule